// File: doc/BRIEF.md
# USB Host Transmit Pre-Fill Controller

This block decides when a USB host may put an outgoing data packet on the bus. Before the packet starts, the transmit latency FIFO has to hold a minimum number of words. For every packet request the controller compares the current FIFO fill level with that minimum. If the level is not yet reached, it estimates whether the missing data can still arrive before the next Start-Of-Frame. The result is one of three verdicts: start now, keep waiting, or back off.

A single 32-bit tuning register holds three fields. The first is a burst-count fill threshold. The second is a scheduler overhead offset, which pads the fill-time estimate by a whole number of time units. The third is a 5-bit saturating health counter that records every back-off. Software clears the counter with any write to the register, then reads the counter back to tune the overhead. The time unit depends on a link-speed input: 1267 ns at high speed and 6333 ns at low or full speed.

The fill-time estimate assumes 4 bytes per word and 40 bytes per microsecond, which is 100 ns per word. The estimate is rounded up to whole time units so that it never comes out too small.

Top module: `txfill_tune`

## Requirements
- R1: After reset every bit of the readback is 0. The readback places the threshold in bits 21:16, the health counter in bits 12:8 and the overhead in bits 7:0. All other bits always read 0.
- R2: A write loads the threshold from write bits 21:16 and the overhead from write bits 7:0. It sets the health counter to 0 whatever value is written to bits 12:8. Writes to the reserved bits are ignored.
- R3: A decision is reported in the cycle after a cycle with `req_valid` high. In that cycle `dec_valid` is high and exactly one of `dec_start`, `dec_wait` and `dec_backoff` is high. In every other cycle all four outputs are 0.
- R4: The packet starts when `fifo_words` is at least the effective threshold times `burst_words`. This holds even when the time check would call for a back-off.
- R5: A programmed threshold of 0 or 1 acts as 2.
- R6: While `stream_off` is high, the programmed threshold is ignored and the effective threshold is 63.
- R7: When the fill level is short, the verdict depends on `sof_left_ns`. Let N be the required words, U the time unit and V the overhead field. The verdict is back-off when `sof_left_ns` ≤ (ceil(N·100/U) + V)·U, and wait otherwise.
- R8: The time unit U is 1267 ns when `speed_hs` is 1 and 6333 ns when it is 0.
- R9: Each back-off verdict increases the health counter by exactly 1. The counter stays at 31 and never wraps.
- R10: A write in the same cycle as a back-off verdict leaves the health counter at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Tuning register write strobe |
| cfg_wr_data | input | 32 | Tuning register write value |
| cfg_rd_data | output | 32 | Tuning register readback |
| stream_off | input | 1 | Stream disable: forces the maximum threshold |
| speed_hs | input | 1 | 1 = high-speed time unit, 0 = low/full-speed time unit |
| req_valid | input | 1 | Packet request, one cycle per request |
| fifo_words | input | 16 | Current latency FIFO fill level in words |
| burst_words | input | 8 | Programmed burst size in words |
| sof_left_ns | input | 24 | Time left before the next Start-Of-Frame, in ns |
| dec_valid | output | 1 | A verdict is present |
| dec_start | output | 1 | Verdict: start the packet |
| dec_wait | output | 1 | Verdict: keep waiting for the fill |
| dec_backoff | output | 1 | Verdict: back off |

## Verification
The bench builds the block with its default parameters. These are a 6-bit threshold, a 5-bit health counter, an 8-bit overhead field, and time units of 1267 ns and 6333 ns. A 24-bit time input covers a whole full-speed frame, so back-off budgets at both speeds can be probed one nanosecond on either side of the boundary. The 5-bit counter saturates after 31 back-offs, so the bench reaches and holds the ceiling within a few dozen requests. The bench also drives a write and a back-off in the same cycle to check that the write wins.

// File: rtl/txfill_pkg.sv
package txfill_pkg;

  // Register field positions: fixed so that software decodes them.
  localparam int THR_LSB  = 16;
  localparam int HLTH_LSB = 8;
  localparam int OVH_LSB  = 0;

  // Integer ceiling division; den is never zero here.
  function automatic logic [31:0] ceil_div(input logic [31:0] num, input logic [31:0] den);
    return (num + den - 32'd1) / den;
  endfunction

  // Fill time for 'words' words, in whole time units, rounded up.
  function automatic logic [31:0] fill_units(input logic [31:0] words,
                                             input logic [31:0] ns_per_word,
                                             input logic [31:0] unit_ns);
    return ceil_div(words * ns_per_word, unit_ns);
  endfunction

  // Latest time before Start-Of-Frame at which a back-off is declared.
  function automatic logic [31:0] budget_ns(input logic [31:0] words,
                                            input logic [31:0] ovh_units,
                                            input logic [31:0] ns_per_word,
                                            input logic [31:0] unit_ns);
    return (fill_units(words, ns_per_word, unit_ns) + ovh_units) * unit_ns;
  endfunction

endpackage

// File: rtl/txfill_regs.sv
module txfill_regs #(
  parameter int THR_W  = 6,
  parameter int HLTH_W = 5,
  parameter int OVH_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              backoff_evt,
  output logic [THR_W-1:0]  thr_q,
  output logic [OVH_W-1:0]  ovh_q,
  output logic [HLTH_W-1:0] health_q,
  output logic [31:0]       rd_data
);
  import txfill_pkg::*;

  localparam logic [HLTH_W-1:0] HLTH_MAX = {HLTH_W{1'b1}};
  localparam logic [31:0] FIELD_MASK =
      ((32'(1) << THR_W) - 32'd1) << THR_LSB |
      ((32'(1) << OVH_W) - 32'd1) << OVH_LSB;

  logic unused_wr_bits;
  assign unused_wr_bits = ^(wr_data & ~FIELD_MASK);

  logic health_at_max;
  assign health_at_max = (health_q == HLTH_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q    <= '0;
      ovh_q    <= '0;
      health_q <= '0;
    end else begin
      if (wr_en) begin
        thr_q <= wr_data[THR_LSB +: THR_W];
        ovh_q <= wr_data[OVH_LSB +: OVH_W];
      end
      if (wr_en)
        health_q <= '0;
      else if (backoff_evt && !health_at_max)
        health_q <= health_q + 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[THR_LSB  +: THR_W]  = thr_q;
    rd_data[HLTH_LSB +: HLTH_W] = health_q;
    rd_data[OVH_LSB  +: OVH_W]  = ovh_q;
  end

  // R2: any write leaves the counter cleared
  p_clear_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> health_q == '0);

  // R9: a back-off without a write counts up by one below the ceiling
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (backoff_evt && !wr_en && !health_at_max) |=> health_q == $past(health_q) + 1'b1);

  // R9: the ceiling holds
  p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (health_at_max && !wr_en) |=> health_q == HLTH_MAX);

  // R9: without events the counter is still
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!backoff_evt && !wr_en) |=> $stable(health_q));

endmodule

// File: rtl/txfill_est.sv
module txfill_est #(
  parameter int THR_W       = 6,
  parameter int OVH_W       = 8,
  parameter int BURST_W     = 8,
  parameter int THR_MIN     = 2,
  parameter int HS_UNIT_NS  = 1267,
  parameter int FS_UNIT_NS  = 6333,
  parameter int NS_PER_WORD = 100
) (
  input  logic [THR_W-1:0]   thr_prog,
  input  logic [OVH_W-1:0]   ovh,
  input  logic               stream_off,
  input  logic               speed_hs,
  input  logic [BURST_W-1:0] burst_words,
  output logic [THR_W-1:0]   eff_thr,
  output logic [31:0]        need_words,
  output logic [31:0]        budget
);
  import txfill_pkg::*;

  localparam logic [THR_W-1:0] THR_MAX = {THR_W{1'b1}};
  localparam logic [THR_W-1:0] THR_LOW = THR_W'(THR_MIN);

  logic [31:0] unit_ns;

  always_comb begin
    if (stream_off)
      eff_thr = THR_MAX;
    else if (thr_prog < THR_LOW)
      eff_thr = THR_LOW;
    else
      eff_thr = thr_prog;
  end

  assign unit_ns    = speed_hs ? 32'(HS_UNIT_NS) : 32'(FS_UNIT_NS);
  assign need_words = 32'(eff_thr) * 32'(burst_words);
  assign budget     = budget_ns(need_words, 32'(ovh), 32'(NS_PER_WORD), unit_ns);

  // R5: the effective threshold never falls below the floor
  always_comb begin
    a_thr_floor_r5: assert (eff_thr >= THR_LOW);
  end

endmodule

// File: rtl/txfill_dec.sv
module txfill_dec #(
  parameter int LVL_W  = 16,
  parameter int TIME_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LVL_W-1:0]  fifo_words,
  input  logic [TIME_W-1:0] sof_left_ns,
  input  logic [31:0]       need_words,
  input  logic [31:0]       budget,
  output logic              backoff_evt,
  output logic              dec_valid,
  output logic              dec_start,
  output logic              dec_wait,
  output logic              dec_backoff
);
  logic fill_met;
  logic time_short;

  assign fill_met    = 32'(fifo_words) >= need_words;
  assign time_short  = 32'(sof_left_ns) <= budget;
  assign backoff_evt = req_valid && !fill_met && time_short;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid   <= 1'b0;
      dec_start   <= 1'b0;
      dec_wait    <= 1'b0;
      dec_backoff <= 1'b0;
    end else begin
      dec_valid   <= req_valid;
      dec_start   <= req_valid && fill_met;
      dec_wait    <= req_valid && !fill_met && !time_short;
      dec_backoff <= backoff_evt;
    end
  end

  // R3: one verdict per request, in the next cycle
  p_verdict_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> dec_valid && $countones({dec_start, dec_wait, dec_backoff}) == 1);

  // R3: no request, no verdict
  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !dec_valid && !dec_start && !dec_wait && !dec_backoff);

  // R4: a filled FIFO always starts, whatever the time left
  p_start_priority_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && 32'(fifo_words) >= need_words) |=> dec_start && !dec_backoff);

  // R7: a back-off pulse is a single cycle without a new request
  p_backoff_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_backoff && !req_valid) |=> !dec_backoff);

endmodule

// File: rtl/txfill_tune.sv
module txfill_tune #(
  parameter int THR_W       = 6,
  parameter int HLTH_W      = 5,
  parameter int OVH_W       = 8,
  parameter int LVL_W       = 16,
  parameter int BURST_W     = 8,
  parameter int TIME_W      = 24,
  parameter int THR_MIN     = 2,
  parameter int HS_UNIT_NS  = 1267,
  parameter int FS_UNIT_NS  = 6333,
  parameter int NS_PER_WORD = 100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [31:0]        cfg_wr_data,
  output logic [31:0]        cfg_rd_data,
  input  logic               stream_off,
  input  logic               speed_hs,
  input  logic               req_valid,
  input  logic [LVL_W-1:0]   fifo_words,
  input  logic [BURST_W-1:0] burst_words,
  input  logic [TIME_W-1:0]  sof_left_ns,
  output logic               dec_valid,
  output logic               dec_start,
  output logic               dec_wait,
  output logic               dec_backoff
);
  logic [THR_W-1:0]  thr_q;
  logic [OVH_W-1:0]  ovh_q;
  logic [HLTH_W-1:0] health_q;
  logic [THR_W-1:0]  eff_thr;
  logic [31:0]       need_words;
  logic [31:0]       budget;
  logic              backoff_evt;

  txfill_regs #(.THR_W(THR_W), .HLTH_W(HLTH_W), .OVH_W(OVH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .backoff_evt(backoff_evt), .thr_q(thr_q), .ovh_q(ovh_q),
    .health_q(health_q), .rd_data(cfg_rd_data)
  );

  txfill_est #(
    .THR_W(THR_W), .OVH_W(OVH_W), .BURST_W(BURST_W), .THR_MIN(THR_MIN),
    .HS_UNIT_NS(HS_UNIT_NS), .FS_UNIT_NS(FS_UNIT_NS), .NS_PER_WORD(NS_PER_WORD)
  ) u_est (
    .thr_prog(thr_q), .ovh(ovh_q), .stream_off(stream_off), .speed_hs(speed_hs),
    .burst_words(burst_words), .eff_thr(eff_thr), .need_words(need_words),
    .budget(budget)
  );

  txfill_dec #(.LVL_W(LVL_W), .TIME_W(TIME_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .fifo_words(fifo_words),
    .sof_left_ns(sof_left_ns), .need_words(need_words), .budget(budget),
    .backoff_evt(backoff_evt), .dec_valid(dec_valid), .dec_start(dec_start),
    .dec_wait(dec_wait), .dec_backoff(dec_backoff)
  );

  // R6: stream disable pins the threshold at its maximum
  p_stream_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stream_off |-> eff_thr == {THR_W{1'b1}});

  // R10: a write racing a back-off still leaves the counter cleared
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && backoff_evt) |=> health_q == '0);

endmodule

// File: tb/txfill_tune_test.sv
`timescale 1ns/1ps
module txfill_tune_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        stream_off = 1'b0;
  logic        speed_hs = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] fifo_words = '0;
  logic [7:0]  burst_words = '0;
  logic [23:0] sof_left_ns = '0;
  logic        dec_valid, dec_start, dec_wait, dec_backoff;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the register
  int m_thr = 0, m_ovh = 0, m_health = 0;

  always #4 clk = ~clk;

  txfill_tune uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .stream_off(stream_off), .speed_hs(speed_hs),
    .req_valid(req_valid), .fifo_words(fifo_words), .burst_words(burst_words),
    .sof_left_ns(sof_left_ns), .dec_valid(dec_valid), .dec_start(dec_start),
    .dec_wait(dec_wait), .dec_backoff(dec_backoff)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd();
    return (32'(m_thr) << 16) | (32'(m_health) << 8) | 32'(m_ovh);
  endfunction

  // verdict code: 1 start, 2 wait, 3 back-off
  function automatic int model_verdict(input int fifo, input int burst, input int sof);
    int eff, need, unit, k;
    eff  = stream_off ? 63 : ((m_thr < 2) ? 2 : m_thr);
    need = eff * burst;
    if (fifo >= need) return 1;
    unit = speed_hs ? 1267 : 6333;
    k = 0;
    while (k * unit < need * 100) k++;
    return (sof <= (k + m_ovh) * unit) ? 3 : 2;
  endfunction

  task automatic write_reg(input logic [31:0] val);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = val;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    m_thr = int'(val[21:16]); m_ovh = int'(val[7:0]); m_health = 0;
  endtask

  task automatic request(input string req, input int fifo, input int burst, input int sof);
    int v;
    v = model_verdict(fifo, burst, sof);
    @(negedge clk);
    req_valid = 1'b1; fifo_words = 16'(fifo); burst_words = 8'(burst); sof_left_ns = 24'(sof);
    @(negedge clk);
    req_valid = 1'b0;
    if (v == 3 && m_health < 31) m_health++;
    chk(req, "dec_valid", dec_valid, 1);
    chk(req, "verdict", {dec_start, dec_wait, dec_backoff},
        (v == 1) ? 3'b100 : (v == 2) ? 3'b010 : 3'b001);
    chk(req, "readback", cfg_rd_data, exp_rd());
  endtask

  task automatic t_reset();
    chk("R1", "reset readback", cfg_rd_data, 0);
    chk("R3", "reset verdict", {dec_valid, dec_start, dec_wait, dec_backoff}, 0);
  endtask

  task automatic t_layout();
    write_reg(32'hFFFF_FFFF);
    chk("R1", "all-ones layout", cfg_rd_data, 32'h003F_00FF);
    write_reg(32'h0005_1F04);
    chk("R2", "health bits ignored", cfg_rd_data, 32'h0005_0004);
  endtask

  task automatic t_idle();
    @(negedge clk);
    @(negedge clk);
    chk("R3", "idle verdict", {dec_valid, dec_start, dec_wait, dec_backoff}, 0);
  endtask

  task automatic t_hs_threshold();
    speed_hs = 1'b1; stream_off = 1'b0;
    // threshold 5, burst 8: 40 words; budget (4+4)*1267 = 10136 ns
    request("R4", 40, 8, 100);
    request("R7", 39, 8, 10136);
    request("R7", 39, 8, 10137);
    request("R8", 0, 8, 10135);
  endtask

  task automatic t_fs_speed();
    speed_hs = 1'b0;
    // full speed: ceil(4000/6333)=1, budget (1+4)*6333 = 31665 ns
    request("R8", 39, 8, 31665);
    request("R8", 39, 8, 31666);
    speed_hs = 1'b1;
  endtask

  task automatic t_min_thr();
    write_reg(32'h0000_0000);
    request("R5", 16, 8, 1_000_000);
    request("R5", 15, 8, 1_000_000);
    write_reg(32'h0001_0000);
    request("R5", 16, 8, 0);
  endtask

  task automatic t_stream_off();
    write_reg(32'h0005_0004);
    stream_off = 1'b1;
    request("R6", 40, 8, 1_000_000);
    request("R6", 504, 8, 0);
    request("R6", 503, 8, 10);
    stream_off = 1'b0;
  endtask

  task automatic t_saturate();
    write_reg(32'h0005_0004);
    for (int i = 0; i < 35; i++) request("R9", 1, 8, 5);
    chk("R9", "saturated health", cfg_rd_data[12:8], 31);
  endtask

  task automatic t_write_race();
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = 32'h0005_0004;
    req_valid = 1'b1; fifo_words = 16'd1; burst_words = 8'd8; sof_left_ns = 24'd5;
    @(negedge clk);
    cfg_wr_en = 1'b0; req_valid = 1'b0;
    m_health = 0;
    chk("R10", "race verdict", dec_backoff, 1);
    chk("R10", "race health", cfg_rd_data[12:8], 0);
    request("R9", 1, 8, 5);
    chk("R9", "count after race", cfg_rd_data[12:8], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_idle();
    t_hs_threshold();
    t_fs_speed();
    t_min_thr();
    t_stream_off();
    t_saturate();
    t_write_race();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule